// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits next to a processor whose bus cycles are announced by a 3-bit status code rather than by separate strobes. It samples that code on every clock. It recognises the start of a bus cycle when the code leaves the all-ones idle value. From the code it produces the discrete system strobes: an address latch pulse, memory read and write strobes, I/O read and write strobes, an interrupt-acknowledge strobe, a transceiver enable and a transceiver direction signal.

Each cycle has two phases. The first is a one-clock address phase, in which the latch pulse fires. The second is a command phase, which holds the decoded strobe until the code returns to idle. An interrupt acknowledge arrives as two back-to-back acknowledge cycles with an idle sample between them, so each one produces its own strobe pulse. A halt cycle produces the latch pulse but no command strobe. The code is captured once, at the start of a cycle. Later changes that do not pass through idle are ignored.

Top module: `bcg_cmd_gen`

## Requirements
- R1: After a synchronous reset (`rst_i` high at a clock edge), all five active-low strobes are high, `ale_o` is 0, `data_en_o` is 0 and `data_dir_o` is 0.
- R2: A cycle starts only at a clock edge where `bus_stat_i` is not 111 and the value sampled at the previous edge was 111. After reset, at least one sample of 111 is required before any cycle can start.
- R3: `ale_o` goes high at the start edge and stays high for exactly one clock.
- R4: At the edge after the start edge, the strobe for the captured code goes low. Codes 100 and 101 drive `mem_rd_n_o`, 110 drives `mem_wr_n_o`, 001 drives `io_rd_n_o`, 010 drives `io_wr_n_o`, and 000 drives `int_ack_n_o`. The strobe stays low until the first edge at which 111 is sampled, and at that edge it goes high.
- R5: Code 011 (halt) drives no strobe low and leaves `data_en_o` at 0.
- R6: `data_en_o` is 1 exactly during the command phase of every non-halt cycle, at the same edges as the strobe.
- R7: `data_dir_o` is 1 for codes 010 and 110, and 0 for all other codes. It is set at the start edge and cleared at the edge where the cycle ends.
- R8: A change of `bus_stat_i` to another non-111 code during a cycle is ignored. The strobe and direction of the captured code are kept.
- R9: If 111 is sampled at the edge right after the start edge, the cycle is dropped. No strobe goes low and `data_en_o` stays 0.
- R10: At most one of the five active-low strobes is low at any time. Two acknowledge cycles separated by one idle sample give two separate `int_ack_n_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_stat_i | input | 3 | Encoded bus-cycle status; 111 means idle |
| ale_o | output | 1 | One-clock address latch pulse, active high |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |
| int_ack_n_o | output | 1 | Interrupt-acknowledge strobe, active low |
| data_en_o | output | 1 | Transceiver enable, active high |
| data_dir_o | output | 1 | Transceiver direction; 1 = data out of the processor |

## Verification
The properties assume that `bus_stat_i` is a settled 3-bit code at every rising edge, with no unknown bits. They also assume that an interrupt-acknowledge pair always has an idle sample between its two cycles, as the processor provides. The bench drives the status only on falling edges, from idle, and holds each code for whole clocks. It breaks the cycle rules only on purpose: an active code held through reset, a code change in the middle of a cycle, and an idle sample right after the latch pulse.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    // Width of the encoded bus status
    localparam int STAT_W = 3;

    // Status code values; the decoder and the idle detector depend on them
    localparam logic [STAT_W-1:0] CODE_ACK   = 3'b000;
    localparam logic [STAT_W-1:0] CODE_IORD  = 3'b001;
    localparam logic [STAT_W-1:0] CODE_IOWR  = 3'b010;
    localparam logic [STAT_W-1:0] CODE_HALT  = 3'b011;
    localparam logic [STAT_W-1:0] CODE_FETCH = 3'b100;
    localparam logic [STAT_W-1:0] CODE_MEMRD = 3'b101;
    localparam logic [STAT_W-1:0] CODE_MEMWR = 3'b110;
    localparam logic [STAT_W-1:0] CODE_IDLE  = 3'b111;

    // Active-high command vector, one bit per strobe
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic ack;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   was_idle;
        logic   ale;
        cmd_t   pend;
        logic   pend_den;
        cmd_t   act;
        logic   den;
        logic   dir;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        ph:       PH_IDLE,
        was_idle: 1'b0,
        ale:      1'b0,
        pend:     '0,
        pend_den: 1'b0,
        act:      '0,
        den:      1'b0,
        dir:      1'b0
    };

endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
    import bcg_pkg::*;
(
    input  logic [STAT_W-1:0] code_i,
    output cmd_t              cmd_o,
    output logic              den_o,
    output logic              dir_o,
    output logic              idle_o
);

    always_comb begin
        cmd_o  = '0;
        den_o  = 1'b1;
        dir_o  = 1'b0;
        idle_o = 1'b0;
        case (code_i)
            CODE_ACK:   cmd_o.ack    = 1'b1;
            CODE_IORD:  cmd_o.io_rd  = 1'b1;
            CODE_IOWR: begin
                cmd_o.io_wr = 1'b1;
                dir_o       = 1'b1;
            end
            CODE_FETCH: cmd_o.mem_rd = 1'b1;
            CODE_MEMRD: cmd_o.mem_rd = 1'b1;
            CODE_MEMWR: begin
                cmd_o.mem_wr = 1'b1;
                dir_o        = 1'b1;
            end
            CODE_HALT:  den_o = 1'b0;
            default: begin
                den_o  = 1'b0;
                idle_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
    import bcg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic idle_i,
    input  cmd_t cmd_i,
    input  logic den_i,
    input  logic dir_i,
    output logic ale_o,
    output cmd_t act_o,
    output logic den_o,
    output logic dir_o
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.was_idle = idle_i;
        seq_d.ale      = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                // Start only on an idle-to-active change
                if (seq_q.was_idle && !idle_i) begin
                    seq_d.ph       = PH_ADDR;
                    seq_d.ale      = 1'b1;
                    seq_d.pend     = cmd_i;
                    seq_d.pend_den = den_i;
                    seq_d.dir      = dir_i;
                end
            end
            PH_ADDR: begin
                if (idle_i) begin
                    seq_d.ph       = PH_IDLE;
                    seq_d.pend     = '0;
                    seq_d.pend_den = 1'b0;
                    seq_d.dir      = 1'b0;
                end else begin
                    seq_d.ph  = PH_DATA;
                    seq_d.act = seq_q.pend;
                    seq_d.den = seq_q.pend_den;
                end
            end
            PH_DATA: begin
                // Captured code is held; only idle ends the cycle
                if (idle_i) begin
                    seq_d.ph       = PH_IDLE;
                    seq_d.act      = '0;
                    seq_d.den      = 1'b0;
                    seq_d.dir      = 1'b0;
                    seq_d.pend     = '0;
                    seq_d.pend_den = 1'b0;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ale_o = seq_q.ale;
    assign act_o = seq_q.act;
    assign den_o = seq_q.den;
    assign dir_o = seq_q.dir;

endmodule

// File: rtl/bcg_cmd_gen.sv
module bcg_cmd_gen
    import bcg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [STAT_W-1:0] bus_stat_i,
    output logic              ale_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic              io_rd_n_o,
    output logic              io_wr_n_o,
    output logic              int_ack_n_o,
    output logic              data_en_o,
    output logic              data_dir_o
);

    cmd_t dec_cmd;
    logic dec_den;
    logic dec_dir;
    logic dec_idle;
    cmd_t act;

    bcg_decode i_decode (
        .code_i (bus_stat_i),
        .cmd_o  (dec_cmd),
        .den_o  (dec_den),
        .dir_o  (dec_dir),
        .idle_o (dec_idle)
    );

    bcg_seq i_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .idle_i (dec_idle),
        .cmd_i  (dec_cmd),
        .den_i  (dec_den),
        .dir_i  (dec_dir),
        .ale_o  (ale_o),
        .act_o  (act),
        .den_o  (data_en_o),
        .dir_o  (data_dir_o)
    );

    assign mem_rd_n_o  = ~act.mem_rd;
    assign mem_wr_n_o  = ~act.mem_wr;
    assign io_rd_n_o   = ~act.io_rd;
    assign io_wr_n_o   = ~act.io_wr;
    assign int_ack_n_o = ~act.ack;

endmodule

// File: rtl/bcg_cmd_gen_chk.sv
module bcg_cmd_gen_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [2:0] bus_stat_i,
    input logic       ale_o,
    input logic       mem_rd_n_o,
    input logic       mem_wr_n_o,
    input logic       io_rd_n_o,
    input logic       io_wr_n_o,
    input logic       int_ack_n_o,
    input logic       data_en_o,
    input logic       data_dir_o
);

    logic [4:0] strb_n;
    assign strb_n = {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o, int_ack_n_o};

    // R2: latch pulse follows an idle sample then an active sample
    p_ale_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |-> ($past(bus_stat_i, 2) == 3'b111 && $past(bus_stat_i) != 3'b111));

    // R3: latch pulse lasts one clock
    p_ale_pulse_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |=> !ale_o);

    // R4: an idle sample leaves every command inactive
    p_end_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(bus_stat_i) == 3'b111 |-> (&strb_n && !data_en_o));

    // R5: halt cycle gives no command phase
    p_halt_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (ale_o && $past(bus_stat_i) == 3'b011) |=> (&strb_n && !data_en_o));

    // R6: a low strobe always comes with the transceiver enable
    p_strobe_den_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(&strb_n) |-> data_en_o);

    // R7: outward direction during data phase only for write strobes
    p_dir_write_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (data_en_o && data_dir_o) |-> (!mem_wr_n_o || !io_wr_n_o));

    p_dir_read_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (data_en_o && !data_dir_o) |-> (mem_wr_n_o && io_wr_n_o));

    // R9: no command during the latch clock
    p_ale_no_cmd_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |-> (&strb_n && !data_en_o));

    // R10: strobes are mutually exclusive
    p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~strb_n));

endmodule

bind bcg_cmd_gen bcg_cmd_gen_chk i_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_stat_i  (bus_stat_i),
    .ale_o       (ale_o),
    .mem_rd_n_o  (mem_rd_n_o),
    .mem_wr_n_o  (mem_wr_n_o),
    .io_rd_n_o   (io_rd_n_o),
    .io_wr_n_o   (io_wr_n_o),
    .int_ack_n_o (int_ack_n_o),
    .data_en_o   (data_en_o),
    .data_dir_o  (data_dir_o)
);

// File: tb/test_bcg_cmd_gen.sv
module test_bcg_cmd_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat = 3'b111;
    logic       ale, mrd_n, mwr_n, iord_n, iowr_n, ack_n, den, dir;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bcg_cmd_gen i_bcg_cmd_gen (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_stat_i  (stat),
        .ale_o       (ale),
        .mem_rd_n_o  (mrd_n),
        .mem_wr_n_o  (mwr_n),
        .io_rd_n_o   (iord_n),
        .io_wr_n_o   (iowr_n),
        .int_ack_n_o (ack_n),
        .data_en_o   (den),
        .data_dir_o  (dir)
    );

    // Observed vector: {ale, mrd_n, mwr_n, iord_n, iowr_n, ack_n, den, dir}
    localparam logic [7:0] OBS_IDLE = 8'b0_11111_0_0;

    function automatic logic [7:0] obs();
        return {ale, mrd_n, mwr_n, iord_n, iowr_n, ack_n, den, dir};
    endfunction

    // Table entry: {code[2:0], active mask {mrd,mwr,iord,iowr,ack}, den, dir}
    localparam logic [9:0] VEC [7] = '{
        {3'b000, 5'b00001, 1'b1, 1'b0},
        {3'b001, 5'b00100, 1'b1, 1'b0},
        {3'b010, 5'b00010, 1'b1, 1'b1},
        {3'b011, 5'b00000, 1'b0, 1'b0},
        {3'b100, 5'b10000, 1'b1, 1'b0},
        {3'b101, 5'b10000, 1'b1, 1'b0},
        {3'b110, 5'b01000, 1'b1, 1'b1}
    };

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Full cycle from idle; status is changed on falling edges only
    task automatic run_cyc(logic [2:0] code, logic [4:0] mask, logic d, logic w,
                           int hold, string tag);
        @(negedge clk) stat = code;
        @(negedge clk) check({tag, " R3 R7 latch"}, obs(), {1'b1, 5'b11111, 1'b0, w});
        @(negedge clk) check({tag, " R4 R6 cmd"}, obs(), {1'b0, ~mask, d, w});
        for (int k = 0; k < hold; k++) begin
            @(negedge clk) check({tag, " R4 hold"}, obs(), {1'b0, ~mask, d, w});
        end
        stat = 3'b111;
        @(negedge clk) check({tag, " R4 end"}, obs(), OBS_IDLE);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk) check("R1 reset", obs(), OBS_IDLE);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            run_cyc(VEC[i][9:7], VEC[i][6:2], VEC[i][1], VEC[i][0], i % 3, "R4 R5 table");
        end

        // R2: idle held gives no latch pulse
        repeat (3) begin
            @(negedge clk) check("R2 idle", obs(), OBS_IDLE);
        end

        // R2: active code held through reset must not start a cycle
        @(negedge clk) begin stat = 3'b101; rst = 1'b1; end
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk) check("R2 no start after reset", obs(), OBS_IDLE);
        end
        @(negedge clk) stat = 3'b111;
        @(negedge clk);
        run_cyc(3'b101, 5'b10000, 1'b1, 1'b0, 1, "R2 start after idle");

        // R10: two acknowledge cycles, one idle sample apart
        run_cyc(3'b000, 5'b00001, 1'b1, 1'b0, 0, "R10 ack first");
        run_cyc(3'b000, 5'b00001, 1'b1, 1'b0, 0, "R10 ack second");

        // R8: mid-cycle code change is ignored
        @(negedge clk) stat = 3'b001;
        @(negedge clk);
        @(negedge clk) begin
            check("R8 io read", obs(), {1'b0, 5'b11011, 1'b1, 1'b0});
            stat = 3'b110;
        end
        @(negedge clk) check("R8 change ignored", obs(), {1'b0, 5'b11011, 1'b1, 1'b0});
        @(negedge clk) check("R8 still held", obs(), {1'b0, 5'b11011, 1'b1, 1'b0});
        stat = 3'b111;
        @(negedge clk) check("R8 end", obs(), OBS_IDLE);

        // R9: idle right after the latch pulse drops the cycle
        @(negedge clk) stat = 3'b110;
        @(negedge clk) begin
            check("R9 latch", obs(), {1'b1, 5'b11111, 1'b0, 1'b1});
            stat = 3'b111;
        end
        @(negedge clk) check("R9 dropped", obs(), OBS_IDLE);
        @(negedge clk) check("R9 stays idle", obs(), OBS_IDLE);

        // R1: reset in the middle of a write cycle
        @(negedge clk) stat = 3'b010;
        @(negedge clk);
        @(negedge clk) begin
            check("R1 pre-reset write", obs(), {1'b0, 5'b11101, 1'b1, 1'b1});
            rst = 1'b1;
        end
        @(negedge clk) check("R1 mid-cycle reset", obs(), OBS_IDLE);
        rst  = 1'b0;
        stat = 3'b111;
        @(negedge clk);
        run_cyc(3'b100, 5'b10000, 1'b1, 1'b0, 0, "R1 R4 fetch after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule